// File: doc/BRIEF.md
# Load/Store Offset Shifter

This block forms the scaled register offset that a word or byte memory access adds to its base address. It takes a 32-bit operand, a 5-bit immediate shift count, a 2-bit shift kind and the processor's current carry flag, and returns the shifted operand. It implements four kinds: logical left, logical right, arithmetic right and rotate right.

A count of zero does not always mean "unshifted". For the two right shifts a zero count stands for a shift by the full word width. For rotate a zero count selects a one-place rotate through the carry flag, which makes a 33-bit rotate. Only the left shift treats zero as a pass-through. The datapath is a logarithmic shifter with one stage per count bit. An optional output register, on by default, gives one cycle of latency. A valid flag travels alongside the result.

Top module: `offset_shifter`

## Requirements
- R1: With kind 2'b00 (logical left), the result is the operand shifted left by the count with zeros filled in; a count of 0 returns the operand unchanged.
- R2: With kind 2'b01 (logical right) and a nonzero count n, the result is the operand shifted right by n with zeros filled in.
- R3: With kind 2'b01 and a count of 0, the result is all zeros (a shift by 32).
- R4: With kind 2'b10 (arithmetic right) and a nonzero count n, the result is the operand shifted right by n with copies of bit 31 filled in.
- R5: With kind 2'b10 and a count of 0, every result bit equals operand bit 31.
- R6: With kind 2'b11 (rotate right) and a nonzero count n, the result is the operand rotated right by n.
- R7: With kind 2'b11 and a count of 0, the result is the carry input in bit 31 followed by operand bits 31:1.
- R8: The carry input has no effect on the result except for kind 2'b11 with a count of 0.
- R9: With the output register enabled, the result and out_valid appear on the clock edge after the inputs are sampled with in_valid high. Synchronous reset clears the result and out_valid to 0. A cycle with in_valid low yields out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is meaningful |
| operand | input | 32 | Register value to be shifted |
| shamt | input | 5 | Immediate shift count |
| kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result is meaningful |
| result | output | 32 | Shifted offset |

## Verification
The hardest case to reach is a zero count on the right shifts and on the rotate. In these cases the carry flag or the sign bit decides the whole output, so an operand with bit 31 clear and carry held at 0 hides most faults. The stimulus therefore sweeps every kind across all 32 counts with both carry values. It does this for several operands that have bit 31 set and bit 0 set, so that sign fill, carry insertion and wrapped rotate bits each leave a mark on the result. The expected values come from a separate arithmetic model.

// File: rtl/offset_shifter_pkg.sv
package offset_shifter_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shift_stage.sv
// One stage of the logarithmic right shifter: moves by DIST places when en is set.
module shift_stage #(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic         en,
  input  logic         rotate,
  input  logic         fill,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [DIST-1:0] top_bits;

  always_comb begin
    top_bits = rotate ? din[DIST-1:0] : {DIST{fill}};
    dout     = en ? {top_bits, din[W-1:DIST]} : din;
  end
endmodule

// File: rtl/shift_core.sv
// Combinational shifter. Left shifts are done by reversing the bit order around the right shifter.
module shift_core
  import offset_shifter_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] shamt,
  input  shift_kind_e   kind,
  input  logic          carry_in,
  output logic [W-1:0]  shifted
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] src;
  logic [W-1:0] stage [AW+1];
  logic         is_left;
  logic         is_rot;
  logic         fill_bit;
  logic         zero_cnt;

  assign is_left  = (kind == SK_LSL);
  assign is_rot   = (kind == SK_ROR);
  assign fill_bit = (kind == SK_ASR) ? operand[W-1] : 1'b0;
  assign zero_cnt = (shamt == '0);

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = operand[W-1-i];
    assign rev_out[i] = stage[AW][W-1-i];
  end

  assign src      = is_left ? rev_in : operand;
  assign stage[0] = src;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    shift_stage #(.W(W), .DIST(1 << k)) u_stage (
      .en    (shamt[k]),
      .rotate(is_rot),
      .fill  (fill_bit),
      .din   (stage[k]),
      .dout  (stage[k+1])
    );
  end

  always_comb begin
    unique case (kind)
      SK_LSL: shifted = rev_out;
      SK_LSR,
      SK_ASR: shifted = zero_cnt ? {W{fill_bit}} : stage[AW];
      SK_ROR: shifted = zero_cnt ? {carry_in, operand[W-1:1]} : stage[AW];
      default: shifted = stage[AW];
    endcase
  end
endmodule

// File: rtl/result_reg.sv
// Optional output register with synchronous reset.
module result_reg #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_d,
  input  logic [W-1:0] dat_d,
  output logic         vld_q,
  output logic [W-1:0] dat_q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else begin
        vld_q <= vld_d;
        dat_q <= dat_d;
      end
    end
  end else begin : g_wire
    assign vld_q = vld_d;
    assign dat_q = dat_d;
  end
endmodule

// File: rtl/offset_shifter.sv
module offset_shifter
  import offset_shifter_pkg::*;
#(
  parameter int W       = 32,
  parameter int AW      = $clog2(W),
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] shamt,
  input  logic [1:0]    kind,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [W-1:0]  result
);
  logic [W-1:0] shifted;
  shift_kind_e  kind_e;

  assign kind_e = shift_kind_e'(kind);

  shift_core #(.W(W), .AW(AW)) u_core (
    .operand (operand),
    .shamt   (shamt),
    .kind    (kind_e),
    .carry_in(carry_in),
    .shifted (shifted)
  );

  result_reg #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk  (clk),
    .rst  (rst),
    .vld_d(in_valid),
    .dat_d(shifted),
    .vld_q(out_valid),
    .dat_q(result)
  );

  if (REG_OUT) begin : g_chk
    p_lsl_zero_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && kind == 2'b00 && shamt == '0) |=> (result == $past(operand)));
    p_lsr_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && kind == 2'b01 && shamt == '0) |=> (result == '0));
    p_asr_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && kind == 2'b10 && shamt == '0) |=> (result == {W{$past(operand[W-1])}}));
    p_rot_carry_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && kind == 2'b11 && shamt == '0) |=>
        (result == {$past(carry_in), $past(operand[W-1:1])}));
    p_vld_on_r9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    p_vld_off_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
  end
endmodule

// File: tb/offset_shifter_tb.sv
module offset_shifter_tb;
  localparam real TCK = 4.0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  shamt = '0;
  logic [1:0]  kind = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  item_t sb [$];

  always #(TCK / 2) clk = ~clk;

  offset_shifter u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .shamt(shamt), .kind(kind), .carry_in(carry_in),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] model(input logic [31:0] v, input int n,
                                        input logic [1:0] k, input logic c);
    logic [63:0] wide;
    case (k)
      2'b00: return v << n;
      2'b01: return (n == 0) ? 32'h0 : (v >> n);
      2'b10: begin
        wide = {{32{v[31]}}, v};
        return (n == 0) ? {32{v[31]}} : wide[n +: 32];
      end
      default: begin
        wide = {v, v};
        return (n == 0) ? {c, v[31:1]} : wide[n +: 32];
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] k, input int n, input logic c);
    if (c && !(k == 2'b11 && n == 0)) return "R8";
    case (k)
      2'b00: return "R1";
      2'b01: return (n == 0) ? "R3" : "R2";
      2'b10: return (n == 0) ? "R5" : "R4";
      default: return (n == 0) ? "R7" : "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] v, input int n, input logic [1:0] k, input logic c);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    operand  = v;
    shamt    = n[4:0];
    kind     = k;
    carry_in = c;
    it.exp   = model(v, n, k, c);
    it.tag   = tag_of(k, n, c);
    sb.push_back(it);
  endtask

  // monitor: compare each valid result against the oldest expected item
  always @(negedge clk) begin
    item_t it;
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check("R9 unexpected out_valid", 32'h1, 32'h0);
      end else begin
        it = sb.pop_front();
        check(it.tag, result, it.exp);
      end
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'hF0E1_D2C3;
    pats[2] = 32'h1234_5679;
    pats[3] = 32'hA5A5_5A5A;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {31'h0, out_valid}, 32'h0);
    check("R9 reset result", result, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle out_valid", {31'h0, out_valid}, 32'h0);
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 32; n++)
          for (int c = 0; c < 2; c++)
            drive(pats[p], n, k[1:0], c[0]);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 valid drops", {31'h0, out_valid}, 32'h0);
    check("R9 queue drained", sb.size(), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog act=hung exp=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule